// File: doc/BRIEF.md
# Dual-Slot Card Access Controller

This block sits between a host that owns an 8-bit multiplexed register port and two common-interface card slots that share one card bus. The host first writes a register index with the phase-select line high. It then reads or writes the chosen register with that line low. A small register file holds the card address, a control byte with slot and space selection, interrupt enables, a channel-control byte and a fixed revision code.

A host access to the data register starts one card cycle. The cycle goes to the slot chosen in the control byte, either to attribute memory or to control space. During the cycle the ready line stays deasserted. When it asserts again, a read has returned its byte on the host data output. The block also sequences a timed reset pulse for each slot, keeps a transport-stream routing enable for each slot, brings the card-ready inputs through a synchronizer as read-only status bits, raises an interrupt when an enabled slot changes state, and drives the stream-output enables and active-low tuner resets of the two channels.

Top module: `ca_dual_slot_ctrl`

## Requirements
- R1: A strobed write (host_cs_n and host_wr_n low on a clock edge) with host_ad_sel high loads the 8-bit register index. A strobed read with host_ad_sel high returns that index on host_dout. With host_ad_sel low, a read or write goes to the indexed register: 0x00 interrupt, 0x01 channel control, 0x04 address low, 0x05 address high, 0x06 card data, 0x07 slot control, 0x0F revision. After reset, slot control reads 0x00 apart from its status bits, channel control reads 0x0C and the interrupt register reads 0x00.
- R2: Address low keeps card address bits [6:0] in register bits [7:1], and its bit 0 always reads 0. Address high keeps card address bits [13:7] in register bits [6:0], and its bit 7 always reads 0. card_addr presents the 14-bit address assembled from both registers.
- R3: A write to the data register starts a card write cycle. For exactly CARD_CYC_CLKS cycles, card_wr_n is low, card_cs_n has only the bit of the selected slot low (bit 0 for slot 0), card_wdata carries the written byte, and host_rdy_n is high. Address, data and space selection stay stable for the whole cycle.
- R4: A read of the data register starts a card read cycle with card_rd_n low for CARD_CYC_CLKS cycles. card_rdata is captured on the last cycle edge, and it appears on host_dout in the same cycle that host_rdy_n returns low.
- R5: While host_rdy_n is high, every host strobe is ignored, including index writes.
- R6: Slot control bit 7 selects the slot (0 or 1) and bit 6 selects control space (1) or attribute memory (0), driven on card_ctl_space. Bit 3 drives slot_ts_en[0] and bit 2 drives slot_ts_en[1]. All of them read back as written.
- R7: Writing slot control with bit 5 set (slot 0) or bit 4 set (slot 1) raises card_rst of that slot for exactly RST_CLKS cycles. The bit reads 1 while the pulse runs and 0 afterwards. Writing 0 to the bit does not cut the pulse short.
- R8: Slot control bit 1 reads the inverse of the synchronized slot_ready[0], and bit 0 reads the inverse of the synchronized slot_ready[1]. Writes to these two bits have no effect.
- R9: Interrupt register bit 6 enables slot 0 and bit 2 enables slot 1. An edge on a synchronized slot_ready input whose slot is enabled sets a pending flag: bit 7 for slot 0, bit 3 for slot 1. irq_n is low while any flag is set. A read of the register returns the flags and clears them. A disabled slot sets no flag.
- R10: In channel control, bit 5 drives ts_out_en[0], bit 4 drives ts_out_en[1], bit 3 drives tuner_rst_n[0] and bit 2 drives tuner_rst_n[1]. The whole byte reads back as written.
- R11: The revision register reads REVISION, and writes to it are ignored.
- R12: Indices with no register read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ad_sel | input | 1 | High: index phase; low: register phase |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_din | input | 8 | Host write data / index |
| host_dout | output | 8 | Host read data |
| host_rdy_n | output | 1 | Low when the port is idle and read data is valid |
| irq_n | output | 1 | Card-change interrupt, active low |
| card_cs_n | output | 2 | Per-slot card select, active low |
| card_rd_n | output | 1 | Card read strobe, active low |
| card_wr_n | output | 1 | Card write strobe, active low |
| card_ctl_space | output | 1 | 1 control space, 0 attribute memory |
| card_addr | output | 14 | Card address |
| card_wdata | output | 8 | Card write data |
| card_rdata | input | 8 | Card read data |
| card_rst | output | 2 | Per-slot card reset pulse |
| slot_ready | input | 2 | Asynchronous card present-and-ready per slot |
| slot_ts_en | output | 2 | Per-slot stream routing enable |
| ts_out_en | output | 2 | Per-channel stream output enable |
| tuner_rst_n | output | 2 | Per-channel tuner reset, active low |

## Verification
The bound checker watches the card bus on every cycle. It checks that host_rdy_n stays high whenever a card strobe is low, that no more than one slot is selected, that read and write strobes never overlap, that the address, data and space selection hold for the whole cycle, and that every cycle and every slot reset pulse has exactly its programmed length. Register encodings, the address bit placement, the way strobes are ignored while busy, status inversion, interrupt set and acknowledge, and the values returned by the card model can only be shown by the bench's directed and randomized host sequences.

// File: rtl/ca_ctrl_pkg.sv
package ca_ctrl_pkg;
   localparam int NUM_SLOTS   = 2;
   localparam int REG_W       = 8;
   localparam int CARD_ADDR_W = 14;

   localparam logic [REG_W-1:0] IDX_INT  = 8'h00;
   localparam logic [REG_W-1:0] IDX_CHAN = 8'h01;
   localparam logic [REG_W-1:0] IDX_ALO  = 8'h04;
   localparam logic [REG_W-1:0] IDX_AHI  = 8'h05;
   localparam logic [REG_W-1:0] IDX_DATA = 8'h06;
   localparam logic [REG_W-1:0] IDX_SLOT = 8'h07;
   localparam logic [REG_W-1:0] IDX_REV  = 8'h0F;

   typedef struct packed {
      logic                   slot;
      logic                   ctl_space;
      logic                   is_read;
      logic [CARD_ADDR_W-1:0] addr;
      logic [REG_W-1:0]       wdata;
   } card_req_t;
endpackage

// File: rtl/ca_card_cycle.sv
module ca_card_cycle
   import ca_ctrl_pkg::*;
#(
   parameter int CYC_CLKS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  card_req_t              req,
   input  logic [REG_W-1:0]       card_rdata,
   output logic                   busy,
   output logic [REG_W-1:0]       rdata_q,
   output logic [NUM_SLOTS-1:0]   card_cs_n,
   output logic                   card_rd_n,
   output logic                   card_wr_n,
   output logic                   card_ctl_space,
   output logic [CARD_ADDR_W-1:0] card_addr,
   output logic [REG_W-1:0]       card_wdata
);
   localparam int CNT_W = $clog2(CYC_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYC_CLKS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   card_req_t        req_q;
   logic             last_cyc;

   assign last_cyc = busy && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt_q   <= '0;
         req_q   <= '0;
         rdata_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_LOAD;
            req_q <= req;
         end
      end else if (last_cyc) begin
         busy <= 1'b0;
         if (req_q.is_read) rdata_q <= card_rdata;
      end else begin
         cnt_q <= cnt_q - CNT_LAST;
      end
   end

   always_comb begin
      card_cs_n = '1;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (busy && (req_q.slot == 1'(s))) card_cs_n[s] = 1'b0;
      end
   end

   assign card_rd_n      = !(busy && req_q.is_read);
   assign card_wr_n      = !(busy && !req_q.is_read);
   assign card_ctl_space = req_q.ctl_space;
   assign card_addr      = req_q.addr;
   assign card_wdata     = req_q.wdata;
endmodule

// File: rtl/ca_slot_reset.sv
module ca_slot_reset #(
   parameter int RST_CLKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CNT_W = $clog2(RST_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CLKS);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            cnt_q  <= CNT_LOAD;
         end
      end else if (cnt_q == CNT_ONE) begin
         active <= 1'b0;
      end else begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end
endmodule

// File: rtl/ca_status_irq.sv
module ca_status_irq
   import ca_ctrl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] ready_async,
   input  logic [NUM_SLOTS-1:0] irq_en,
   input  logic                 ack,
   output logic [NUM_SLOTS-1:0] ready_s,
   output logic [NUM_SLOTS-1:0] pending
);
   logic [NUM_SLOTS-1:0] sync_q [SYNC_STAGES];
   logic [NUM_SLOTS-1:0] prev_q;
   logic [NUM_SLOTS-1:0] change;

   assign ready_s = sync_q[SYNC_STAGES-1];
   assign change  = ready_s ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
         prev_q  <= '0;
         pending <= '0;
      end else begin
         sync_q[0] <= ready_async;
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
         prev_q  <= ready_s;
         pending <= (pending & ~{NUM_SLOTS{ack}}) | (change & irq_en);
      end
   end
endmodule

// File: rtl/ca_dual_slot_ctrl.sv
module ca_dual_slot_ctrl
   import ca_ctrl_pkg::*;
#(
   parameter int         CARD_CYC_CLKS = 4,
   parameter int         RST_CLKS      = 1000,
   parameter int         SYNC_STAGES   = 2,
   parameter logic [7:0] REVISION      = 8'h21
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_cs_n,
   input  logic                   host_ad_sel,
   input  logic                   host_wr_n,
   input  logic                   host_rd_n,
   input  logic [7:0]             host_din,
   output logic [7:0]             host_dout,
   output logic                   host_rdy_n,
   output logic                   irq_n,
   output logic [1:0]             card_cs_n,
   output logic                   card_rd_n,
   output logic                   card_wr_n,
   output logic                   card_ctl_space,
   output logic [13:0]            card_addr,
   output logic [7:0]             card_wdata,
   input  logic [7:0]             card_rdata,
   output logic [1:0]             card_rst,
   input  logic [1:0]             slot_ready,
   output logic [1:0]             slot_ts_en,
   output logic [1:0]             ts_out_en,
   output logic [1:0]             tuner_rst_n
);
   localparam int AHI_W = CARD_ADDR_W - 7;
   localparam logic [REG_W-1:0] CHAN_RESET = 8'h0C;

   generate
      if (CARD_CYC_CLKS < 1) begin : g_bad_cyc
         $error("CARD_CYC_CLKS must be at least 1");
      end
      if (RST_CLKS < 1) begin : g_bad_rst
         $error("RST_CLKS must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   // host strobe decode
   logic cyc_busy;
   logic wr_stb, rd_stb, reg_wr, reg_rd;
   assign wr_stb = !host_cs_n && !host_wr_n && !cyc_busy;
   assign rd_stb = !host_cs_n && !host_rd_n && host_wr_n && !cyc_busy;
   assign reg_wr = wr_stb && !host_ad_sel;
   assign reg_rd = rd_stb && !host_ad_sel;

   // register state
   logic [REG_W-1:0]     idx_q;
   logic [6:0]           alo_q;
   logic [AHI_W-1:0]     ahi_q;
   logic                 sel_slot_q;
   logic                 sel_ctl_q;
   logic [NUM_SLOTS-1:0] ts_en_q;
   logic [NUM_SLOTS-1:0] irq_en_q;
   logic [REG_W-1:0]     chan_q;
   logic [REG_W-1:0]     reg_dout_q;
   logic                 dout_card_q;

   logic hit_data, hit_slot, hit_int;
   assign hit_data = (idx_q == IDX_DATA);
   assign hit_slot = (idx_q == IDX_SLOT);
   assign hit_int  = (idx_q == IDX_INT);

   // card cycle engine
   card_req_t        req;
   logic             cyc_start;
   logic [REG_W-1:0] cyc_rdata;

   assign cyc_start     = (reg_wr || reg_rd) && hit_data;
   assign req.slot      = sel_slot_q;
   assign req.ctl_space = sel_ctl_q;
   assign req.is_read   = reg_rd;
   assign req.addr      = {ahi_q, alo_q};
   assign req.wdata     = host_din;

   ca_card_cycle #(.CYC_CLKS(CARD_CYC_CLKS)) i_cycle (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (cyc_start),
      .req            (req),
      .card_rdata     (card_rdata),
      .busy           (cyc_busy),
      .rdata_q        (cyc_rdata),
      .card_cs_n      (card_cs_n),
      .card_rd_n      (card_rd_n),
      .card_wr_n      (card_wr_n),
      .card_ctl_space (card_ctl_space),
      .card_addr      (card_addr),
      .card_wdata     (card_wdata)
   );

   // per-slot reset sequencers; slot s is started by slot-control bit (5 - s)
   logic [NUM_SLOTS-1:0] rst_act;
   genvar gs;
   generate
      for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot_rst
         logic start_s;
         assign start_s = reg_wr && hit_slot && host_din[5-gs];
         ca_slot_reset #(.RST_CLKS(RST_CLKS)) i_rst (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start_s),
            .active (rst_act[gs])
         );
      end
   endgenerate
   assign card_rst = rst_act;

   // status synchronizer and change interrupt
   logic [NUM_SLOTS-1:0] ready_s;
   logic [NUM_SLOTS-1:0] irq_pend;
   logic                 irq_ack;
   assign irq_ack = reg_rd && hit_int;

   ca_status_irq #(.SYNC_STAGES(SYNC_STAGES)) i_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .ready_async (slot_ready),
      .irq_en      (irq_en_q),
      .ack         (irq_ack),
      .ready_s     (ready_s),
      .pending     (irq_pend)
   );
   assign irq_n = ~|irq_pend;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q      <= '0;
         alo_q      <= '0;
         ahi_q      <= '0;
         sel_slot_q <= 1'b0;
         sel_ctl_q  <= 1'b0;
         ts_en_q    <= '0;
         irq_en_q   <= '0;
         chan_q     <= CHAN_RESET;
      end else if (wr_stb && host_ad_sel) begin
         idx_q <= host_din;
      end else if (reg_wr) begin
         unique case (idx_q)
            IDX_ALO:  alo_q <= host_din[7:1];
            IDX_AHI:  ahi_q <= host_din[AHI_W-1:0];
            IDX_SLOT: begin
               sel_slot_q <= host_din[7];
               sel_ctl_q  <= host_din[6];
               ts_en_q[0] <= host_din[3];
               ts_en_q[1] <= host_din[2];
            end
            IDX_INT: begin
               irq_en_q[0] <= host_din[6];
               irq_en_q[1] <= host_din[2];
            end
            IDX_CHAN: chan_q <= host_din;
            default: ;
         endcase
      end
   end

   // read mux
   logic [REG_W-1:0] rd_val;
   always_comb begin
      unique case (idx_q)
         IDX_INT:  rd_val = {irq_pend[0], irq_en_q[0], 2'b00, irq_pend[1], irq_en_q[1], 2'b00};
         IDX_CHAN: rd_val = chan_q;
         IDX_ALO:  rd_val = {alo_q, 1'b0};
         IDX_AHI:  rd_val = {{(REG_W-AHI_W){1'b0}}, ahi_q};
         IDX_SLOT: rd_val = {sel_slot_q, sel_ctl_q, rst_act[0], rst_act[1],
                             ts_en_q[0], ts_en_q[1], ~ready_s[0], ~ready_s[1]};
         IDX_REV:  rd_val = REVISION;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_dout_q  <= '0;
         dout_card_q <= 1'b0;
      end else if (rd_stb) begin
         if (host_ad_sel) begin
            reg_dout_q  <= idx_q;
            dout_card_q <= 1'b0;
         end else if (hit_data) begin
            dout_card_q <= 1'b1;
         end else begin
            reg_dout_q  <= rd_val;
            dout_card_q <= 1'b0;
         end
      end
   end

   assign host_dout   = dout_card_q ? cyc_rdata : reg_dout_q;
   assign host_rdy_n  = cyc_busy;
   assign slot_ts_en  = ts_en_q;
   assign ts_out_en   = {chan_q[4], chan_q[5]};
   assign tuner_rst_n = {chan_q[2], chan_q[3]};
endmodule

// File: rtl/ca_ctrl_checker.sv
module ca_ctrl_checker #(
   parameter int CARD_CYC_CLKS = 4,
   parameter int RST_CLKS      = 1000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        host_rdy_n,
   input logic [1:0]  card_cs_n,
   input logic        card_rd_n,
   input logic        card_wr_n,
   input logic        card_ctl_space,
   input logic [13:0] card_addr,
   input logic [7:0]  card_wdata,
   input logic [1:0]  card_rst
);
   int busy_len;
   int rst_len0;
   int rst_len1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_len <= 0;
         rst_len0 <= 0;
         rst_len1 <= 0;
      end else begin
         busy_len <= host_rdy_n  ? busy_len + 1 : 0;
         rst_len0 <= card_rst[0] ? rst_len0 + 1 : 0;
         rst_len1 <= card_rst[1] ? rst_len1 + 1 : 0;
      end
   end

   AST_RDY_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_rd_n || !card_wr_n) |-> host_rdy_n); // R3
   AST_ONE_SLOT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~card_cs_n) <= 1); // R3
   AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!card_rd_n && !card_wr_n)); // R4
   AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (card_cs_n != 2'b11 && $past(card_cs_n) != 2'b11)
      |-> ($stable(card_addr) && $stable(card_wdata) && $stable(card_ctl_space))); // R3
   AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_rdy_n) |-> (busy_len == CARD_CYC_CLKS)); // R3
   AST_RST0_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_rst[0]) |-> (rst_len0 == RST_CLKS)); // R7
   AST_RST1_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_rst[1]) |-> (rst_len1 == RST_CLKS)); // R7
endmodule

bind ca_dual_slot_ctrl ca_ctrl_checker #(
   .CARD_CYC_CLKS (CARD_CYC_CLKS),
   .RST_CLKS      (RST_CLKS)
) i_ca_ctrl_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_rdy_n     (host_rdy_n),
   .card_cs_n      (card_cs_n),
   .card_rd_n      (card_rd_n),
   .card_wr_n      (card_wr_n),
   .card_ctl_space (card_ctl_space),
   .card_addr      (card_addr),
   .card_wdata     (card_wdata),
   .card_rst       (card_rst)
);

// File: tb/test_ca_dual_slot_ctrl.sv
module test_ca_dual_slot_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 3;
   localparam int RSTC       = 16;
   localparam logic [7:0] REV = 8'hA7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_cs_n = 1'b1, host_ad_sel = 1'b0, host_wr_n = 1'b1, host_rd_n = 1'b1;
   logic [7:0] host_din = '0;
   logic [7:0] host_dout;
   logic host_rdy_n, irq_n;
   logic [1:0] card_cs_n;
   logic card_rd_n, card_wr_n, card_ctl_space;
   logic [13:0] card_addr;
   logic [7:0] card_wdata, card_rdata;
   logic [1:0] card_rst;
   logic [1:0] slot_ready = 2'b00;
   logic [1:0] slot_ts_en, ts_out_en, tuner_rst_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ca_dual_slot_ctrl #(
      .CARD_CYC_CLKS(CYC), .RST_CLKS(RSTC), .SYNC_STAGES(2), .REVISION(REV)
   ) i_ca_dual_slot_ctrl (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_ad_sel(host_ad_sel),
      .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_din(host_din),
      .host_dout(host_dout), .host_rdy_n(host_rdy_n), .irq_n(irq_n),
      .card_cs_n(card_cs_n), .card_rd_n(card_rd_n), .card_wr_n(card_wr_n),
      .card_ctl_space(card_ctl_space), .card_addr(card_addr), .card_wdata(card_wdata),
      .card_rdata(card_rdata), .card_rst(card_rst), .slot_ready(slot_ready),
      .slot_ts_en(slot_ts_en), .ts_out_en(ts_out_en), .tuner_rst_n(tuner_rst_n)
   );

   // card model: byte returned depends on slot, space and address
   function automatic logic [7:0] card_model(input logic slot, input logic ctl, input logic [13:0] a);
      return a[7:0] ^ {a[13:8], 2'b01} ^ (slot ? 8'h5A : 8'h00) ^ (ctl ? 8'hC3 : 8'h00);
   endfunction

   assign card_rdata = (!card_rd_n) ? card_model(card_cs_n[0], card_ctl_space, card_addr) : 8'h00;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input bit ad, input bit rd, input logic [7:0] v);
      @(negedge clk);
      host_cs_n = 1'b0; host_ad_sel = ad; host_din = v;
      if (rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
      @(negedge clk);
      host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (host_rdy_n && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
      strobe(1'b1, 1'b0, idx);
      strobe(1'b0, 1'b0, v);
      wait_idle();
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [7:0] v);
      strobe(1'b1, 1'b0, idx);
      strobe(1'b0, 1'b1, 8'h00);
      wait_idle();
      v = host_dout;
   endtask

   task automatic card_access(input bit slot, input bit ctl, input bit rd,
                              input logic [13:0] a, input logic [7:0] wd,
                              output logic [7:0] rdv);
      int n = 0;
      bit ok = 1'b1;
      reg_write(8'h04, {a[6:0], 1'($urandom)});
      reg_write(8'h05, {1'($urandom), a[13:7]});
      reg_write(8'h07, {slot, ctl, 6'b000000});
      strobe(1'b1, 1'b0, 8'h06);
      strobe(1'b0, rd, wd);
      while (host_rdy_n && n < 100) begin
         if (card_cs_n !== ~(2'b01 << slot)) ok = 1'b0;
         if (card_rd_n !== !rd || card_wr_n !== rd) ok = 1'b0;
         if (card_addr !== a || card_ctl_space !== ctl) ok = 1'b0;
         if (!rd && card_wdata !== wd) ok = 1'b0;
         n++;
         @(negedge clk);
      end
      if (rd) chk("R4 read cycle shape/length", ok ? n : 999, CYC);
      else    chk("R3 write cycle shape/length", ok ? n : 999, CYC);
      rdv = host_dout;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      process::self().srandom(32'h1234_5678);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rdy after reset", host_rdy_n, 0);
      chk("R3 card idle after reset", {card_cs_n, card_rd_n, card_wr_n}, 4'b1111);
      chk("R10 tuner/ts after reset", {tuner_rst_n, ts_out_en}, 4'b1100);
      chk("R9 irq after reset", irq_n, 1);
      reg_read(8'h07, v); chk("R1 slot ctrl reset", v, 8'h03);
      reg_read(8'h01, v); chk("R1 chan ctrl reset", v, 8'h0C);
      reg_read(8'h00, v); chk("R1 int reset", v, 8'h00);
      strobe(1'b1, 1'b1, 8'h00); chk("R1 index readback", host_dout, 8'h00);

      // R11 revision
      reg_write(8'h0F, 8'h00);
      reg_read(8'h0F, v); chk("R11 revision", v, REV);

      // R12 undefined index
      reg_write(8'h02, 8'hFF);
      reg_read(8'h02, v); chk("R12 hole reads zero", v, 8'h00);
      reg_read(8'h01, v); chk("R12 hole write side effect", v, 8'h0C);

      // R2 address placement
      reg_write(8'h04, 8'hFF);
      reg_read(8'h04, v); chk("R2 addr low bit0 zero", v, 8'hFE);
      reg_write(8'h05, 8'hFF);
      reg_read(8'h05, v); chk("R2 addr high bit7 zero", v, 8'h7F);

      // R6 selection and stream routing bits
      reg_write(8'h07, 8'hCC);
      reg_read(8'h07, v); chk("R6 slot ctrl readback", v, 8'hCF);
      chk("R6 slot_ts_en", slot_ts_en, 2'b11);
      reg_write(8'h07, 8'h08);
      chk("R6 slot_ts_en slot0 only", slot_ts_en, 2'b01);

      // R10 channel control
      reg_write(8'h01, 8'h30);
      chk("R10 ts_out_en", ts_out_en, 2'b11);
      chk("R10 tuner_rst_n asserted", tuner_rst_n, 2'b00);
      reg_write(8'h01, 8'h28);
      chk("R10 ch0 only", {ts_out_en, tuner_rst_n}, 4'b0101);
      reg_read(8'h01, v); chk("R10 readback", v, 8'h28);

      // R7 slot 1 exact pulse length
      reg_write(8'h07, 8'h10);
      begin
         int n = 0;
         while (card_rst[1] && n < 1000) begin n++; @(negedge clk); end
         chk("R7 slot1 pulse length", n, RSTC);
      end
      // R7 slot 0 readback and no abort
      reg_write(8'h07, 8'h20);
      chk("R7 slot0 pulse started", card_rst, 2'b01);
      reg_read(8'h07, v); chk("R7 busy bit reads 1", v, 8'h23);
      reg_write(8'h07, 8'h00);
      chk("R7 write 0 does not abort", card_rst[0], 1);
      begin
         int n = 0;
         while (card_rst[0] && n < 1000) begin n++; @(negedge clk); end
      end
      reg_read(8'h07, v); chk("R7 busy bit clears", v, 8'h03);

      // R8 status inversion and read-only
      slot_ready = 2'b01;
      repeat (5) @(negedge clk);
      reg_read(8'h07, v); chk("R8 slot0 ready", v, 8'h01);
      reg_write(8'h07, 8'h03);
      reg_read(8'h07, v); chk("R8 status not writable", v, 8'h01);
      chk("R9 no irq while disabled", irq_n, 1);

      // R9 interrupts
      reg_write(8'h00, 8'h44);
      slot_ready = 2'b11;
      repeat (5) @(negedge clk);
      chk("R9 irq asserted", irq_n, 0);
      reg_read(8'h00, v); chk("R9 pending slot1", v, 8'h4C);
      chk("R9 ack clears irq", irq_n, 1);
      reg_read(8'h00, v); chk("R9 pending cleared", v, 8'h44);
      reg_write(8'h00, 8'h04);
      slot_ready = 2'b10;
      repeat (5) @(negedge clk);
      chk("R9 disabled slot0 no irq", irq_n, 1);
      slot_ready = 2'b00;
      repeat (5) @(negedge clk);
      reg_read(8'h00, v); chk("R9 slot1 flag only", v, 8'h0C);
      reg_write(8'h00, 8'h00);

      // R5 strobes ignored while busy
      reg_write(8'h07, 8'h00);
      strobe(1'b1, 1'b0, 8'h06);
      strobe(1'b0, 1'b0, 8'h11);
      strobe(1'b1, 1'b0, 8'h0F);
      wait_idle();
      strobe(1'b1, 1'b1, 8'h00); chk("R5 index write ignored while busy", host_dout, 8'h06);

      // R3 / R4 directed corners
      card_access(1'b0, 1'b0, 1'b0, 14'h0000, 8'hA5, v);
      card_access(1'b1, 1'b1, 1'b1, 14'h3FFF, 8'h00, v);
      chk("R4 read data max address", v, card_model(1'b1, 1'b1, 14'h3FFF));

      // randomized card cycles
      for (int i = 0; i < 40; i++) begin
         bit s = 1'($urandom);
         bit c = 1'($urandom);
         bit r = 1'($urandom);
         logic [13:0] a = 14'($urandom);
         logic [7:0] d = 8'($urandom);
         card_access(s, c, r, a, d, v);
         if (r) chk("R4 random read data", v, card_model(s, c, a));
         else   chk("R6 space select on write", card_ctl_space, c);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule